// File: doc/BRIEF.md
# Multi-Channel Compare Match Timer

This peripheral holds several independent timer channels behind one word-addressed register bus. Each channel owns a control/status register, an up-counter and a compare register. A single run register, shared by all channels, holds one run bit per channel, so software can start or stop any set of channels with one write. While a channel runs, a per-channel prescaler derives a count tick from the clock. On the tick where the counter equals the compare value, a sticky match flag is set. In periodic mode the counter also restarts from zero. The match flag drives the channel's interrupt when the interrupt is enabled.

Each channel is built as a 16-bit or a 32-bit variant, chosen by a parameter bit. The variant also sets the position of the status flags. The compare register may be rewritten while the channel counts, and the new value is used from the next cycle on. If the new value is below the counter, the counter runs on to all ones and wraps to zero. That wrap sets a wrap flag but not the match flag. Each channel tracks this with a small state machine. STOP is entered from any state when the run bit is low (halt). STOP goes to COUNT when started with the counter at or below compare (start), or to OVER when started with the counter above compare (start_above). COUNT goes to OVER when a compare write or a free-running pass puts the counter above compare (pass). OVER goes back to COUNT on full-range wrap or when compare is raised to the counter or above (rejoin).

Top module: `cmt_timer`

## Requirements
- R1: After reset the run register, every control/status register and every counter read 0. A 16-bit channel's compare reads 0x0000FFFF and a 32-bit channel's compare reads 0xFFFFFFFF. All interrupts are low.
- R2: Word address 0 is the run register: bit i runs channel i. One write updates all run bits in the same cycle, and a read returns the current run bits. Channel i occupies word addresses 4*(i+1)+0 (control/status), +1 (counter) and +2 (compare).
- R3: Control bits [2:0] select the tick. Code 100 gives one tick per 8 clocks, and the first increment comes 8 clocks after the run bit is set. Code 000 gives one tick per clock, and the first increment comes on the first clock after the run bit is set.
- R4: On a tick where the counter equals the compare value, the match flag is set. The flag is bit 7 in a 16-bit channel and bit 15 in a 32-bit channel. With control bit 5 set (periodic), the counter becomes 0 on that tick. With bit 5 clear, the counter keeps incrementing.
- R5: When the counter is above the compare value, it counts up to all ones for its width and wraps to 0. The wrap sets the wrap flag (bit 6 in a 16-bit channel, bit 14 in a 32-bit channel) and leaves the match flag clear.
- R6: Writing 0 to a status flag bit clears it. Writing 1 to it leaves it unchanged. A match on the same clock as a clearing write leaves the match flag set.
- R7: A channel's interrupt is high exactly when its match flag and its interrupt enable (control bit 8) are both 1.
- R8: Clearing the run bit freezes the counter. A counter write loads the value only while the channel is stopped. While the channel runs, the write is ignored.
- R9: A compare write while running takes effect on the next tick. A lowered compare below the counter leads to the behaviour of R5. A raised compare is matched when the counter reaches it.
- R10: Control/status bits other than 2:0, 5, 8 and the two flag bits read 0, and bits 31:16 read 0. A 16-bit channel keeps only the low 16 bits of counter and compare writes and reads them zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle while bus_sel is high |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
The hardest condition to reach is a counter sitting above its compare value. Two cases matter: the flags must stay quiet through the full-range run-up, and the wrap must be seen. The stimulus gets there in two ways. In the first, the counter is preloaded near all ones while stopped and the compare is set low before starting. In the second, the compare is lowered under a running counter at a counted cycle and later raised above it. The same-cycle collision of a match with a flag-clearing write is placed by counting ticks at one tick per clock from the start edge.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_COUNT = 2'd1,
        ST_OVER  = 2'd2
    } ch_state_t;

    localparam int BUS_W   = 32;
    localparam int CSR_W   = 16;
    localparam int PRE_W   = 9;
    localparam int CSR_PER = 5;
    localparam int CSR_IE  = 8;

    localparam logic [1:0] SUB_CSR = 2'd0;
    localparam logic [1:0] SUB_CNT = 2'd1;
    localparam logic [1:0] SUB_CMP = 2'd2;

    function automatic int flag_pos(input bit wide);
        return wide ? 15 : 7;
    endfunction

    function automatic int wrap_pos(input bit wide);
        return wide ? 14 : 6;
    endfunction

    // tick select: bit 2 set -> 8 * 4^sel[1:0], clear -> 4^sel[1:0]
    function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] sel);
        int e;
        e = sel[2] ? 3 + 2 * int'(sel[1:0]) : 2 * int'(sel[1:0]);
        return PRE_W'((1 << e) - 1);
    endfunction

endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] mask;

    assign mask = div_mask(sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!run) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assign tick = run && ((pcnt & mask) == mask);

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter bit WIDE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             csr_we,
    input  logic             cnt_we,
    input  logic             cmp_we,
    input  logic [BUS_W-1:0] wdata,
    output logic [2:0]       sel_o,
    output logic [CSR_W-1:0] csr_rd,
    output logic [BUS_W-1:0] cnt_rd,
    output logic [BUS_W-1:0] cmp_rd,
    output logic             irq,
    output ch_state_t        state_o
);

    localparam int CNT_W  = WIDE ? 32 : 16;
    localparam int FLAG_B = flag_pos(WIDE);
    localparam int WRAP_B = wrap_pos(WIDE);

    ch_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cmp_q, cmp_d;
    logic [2:0]       sel_q;
    logic             per_q, ie_q;
    logic             match_q, match_d;
    logic             wrap_q, wrap_d;
    logic             hit, restart, roll, above;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    // count events
    always_comb begin
        hit     = tick && (state_q != ST_OVER) && (cnt_q == cmp_q);
        restart = hit && per_q;
        roll    = tick && (cnt_q == {CNT_W{1'b1}}) && !restart;

        if (!run) begin
            cnt_d = cnt_we ? wdata[CNT_W-1:0] : cnt_q;
        end else if (tick) begin
            cnt_d = restart ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end

        cmp_d   = cmp_we ? wdata[CNT_W-1:0] : cmp_q;
        above   = cnt_d > cmp_d;
        match_d = hit  || (match_q && !(csr_we && !wdata[FLAG_B]));
        wrap_d  = roll || (wrap_q  && !(csr_we && !wdata[WRAP_B]));
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (run) state_d = above ? ST_OVER : ST_COUNT;
            end
            ST_COUNT: begin
                if (!run)       state_d = ST_STOP;
                else if (above) state_d = ST_OVER;
            end
            ST_OVER: begin
                if (!run)        state_d = ST_STOP;
                else if (!above) state_d = ST_COUNT;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cmp_q   <= '1;
            sel_q   <= '0;
            per_q   <= 1'b0;
            ie_q    <= 1'b0;
            match_q <= 1'b0;
            wrap_q  <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            cmp_q   <= cmp_d;
            match_q <= match_d;
            wrap_q  <= wrap_d;
            if (csr_we) begin
                sel_q <= wdata[2:0];
                per_q <= wdata[CSR_PER];
                ie_q  <= wdata[CSR_IE];
            end
        end
    end

    // outputs
    always_comb begin
        csr_rd          = '0;
        csr_rd[2:0]     = sel_q;
        csr_rd[CSR_PER] = per_q;
        csr_rd[CSR_IE]  = ie_q;
        csr_rd[FLAG_B]  = match_q;
        csr_rd[WRAP_B]  = wrap_q;
        cnt_rd          = BUS_W'(cnt_q);
        cmp_rd          = BUS_W'(cmp_q);
        irq             = match_q && ie_q;
        sel_o           = sel_q;
        state_o         = state_q;
    end

endmodule

// File: rtl/cmt_regbus.sv
module cmt_regbus
    import cmt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [BUS_W-1:0]             bus_wdata,
    input  logic [NUM_CH-1:0][CSR_W-1:0] csr_rd,
    input  logic [NUM_CH-1:0][BUS_W-1:0] cnt_rd,
    input  logic [NUM_CH-1:0][BUS_W-1:0] cmp_rd,
    output logic [BUS_W-1:0]             bus_rdata,
    output logic [NUM_CH-1:0]            run_q,
    output logic [NUM_CH-1:0]            csr_we,
    output logic [NUM_CH-1:0]            cnt_we,
    output logic [NUM_CH-1:0]            cmp_we
);

    localparam int GRP_W = ADDR_W - 2;

    logic [GRP_W-1:0] grp;
    logic [1:0]       sub;
    logic             is_run, wr;
    logic             unused_wdata;

    assign grp          = bus_addr[ADDR_W-1:2];
    assign sub          = bus_addr[1:0];
    assign is_run       = (bus_addr == '0);
    assign wr           = bus_sel && bus_we;
    assign unused_wdata = ^bus_wdata;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        logic mine;
        assign mine      = (grp == GRP_W'(i + 1));
        assign csr_we[i] = wr && mine && (sub == SUB_CSR);
        assign cnt_we[i] = wr && mine && (sub == SUB_CNT);
        assign cmp_we[i] = wr && mine && (sub == SUB_CMP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_q <= '0;
        else if (wr && is_run) run_q <= bus_wdata[NUM_CH-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (is_run) bus_rdata = BUS_W'(run_q);
            for (int i = 0; i < NUM_CH; i++) begin
                if (grp == GRP_W'(i + 1)) begin
                    if (sub == SUB_CSR) bus_rdata = BUS_W'(csr_rd[i]);
                    if (sub == SUB_CNT) bus_rdata = cnt_rd[i];
                    if (sub == SUB_CMP) bus_rdata = cmp_rd[i];
                end
            end
        end
    end

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int          NUM_CH  = 2,
    parameter logic [31:0] CH_WIDE = 32'h2,
    parameter int          ADDR_W  = $clog2(4 * (NUM_CH + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0][CSR_W-1:0] csr_rd;
    logic [NUM_CH-1:0][BUS_W-1:0] cnt_rd;
    logic [NUM_CH-1:0][BUS_W-1:0] cmp_rd;
    logic [NUM_CH-1:0]            run_q, csr_we, cnt_we, cmp_we;
    logic [NUM_CH-1:0]            tick, ch_over;
    logic [NUM_CH-1:0][2:0]       ch_sel;
    ch_state_t                    ch_state [NUM_CH];

    cmt_regbus #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) i_regbus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .csr_rd    (csr_rd),
        .cnt_rd    (cnt_rd),
        .cmp_rd    (cmp_rd),
        .bus_rdata (bus_rdata),
        .run_q     (run_q),
        .csr_we    (csr_we),
        .cnt_we    (cnt_we),
        .cmp_we    (cmp_we)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        cmt_prescale i_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run_q[i]),
            .sel   (ch_sel[i]),
            .tick  (tick[i])
        );

        cmt_channel #(
            .WIDE (CH_WIDE[i])
        ) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_q[i]),
            .tick    (tick[i]),
            .csr_we  (csr_we[i]),
            .cnt_we  (cnt_we[i]),
            .cmp_we  (cmp_we[i]),
            .wdata   (bus_wdata),
            .sel_o   (ch_sel[i]),
            .csr_rd  (csr_rd[i]),
            .cnt_rd  (cnt_rd[i]),
            .cmp_rd  (cmp_rd[i]),
            .irq     (irq[i]),
            .state_o (ch_state[i])
        );

        assign ch_over[i] = (ch_state[i] == ST_OVER);
    end

endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
    parameter int          NUM_CH  = 2,
    parameter logic [31:0] CH_WIDE = 32'h2,
    parameter int          ADDR_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_sel,
    input logic                    bus_we,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [NUM_CH-1:0]       irq,
    input logic [NUM_CH-1:0]       run_q,
    input logic [NUM_CH-1:0][15:0] csr_rd,
    input logic [NUM_CH-1:0][31:0] cnt_rd,
    input logic [NUM_CH-1:0]       ch_over
);

    logic unused_chk;
    assign unused_chk = ^{bus_wdata, csr_rd, cnt_rd};

    assert_run_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == '0) |=> run_q == $past(bus_wdata[NUM_CH-1:0]));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        localparam int FB = CH_WIDE[i] ? 15 : 7;
        logic cnt_wr;
        assign cnt_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(4 * (i + 1) + 1));

        assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] == (csr_rd[i][FB] && csr_rd[i][8]));

        assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[i] && !cnt_wr) |=> $stable(cnt_rd[i]));

        assert_no_match_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_over[i] && !csr_rd[i][FB]) |=> !csr_rd[i][FB]);

        assert_periodic_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(csr_rd[i][FB]) && csr_rd[i][5] && $past(csr_rd[i][5])) |-> cnt_rd[i] == 32'd0);
    end

endmodule

bind cmt_timer cmt_timer_chk #(
    .NUM_CH  (NUM_CH),
    .CH_WIDE (CH_WIDE),
    .ADDR_W  (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run_q     (run_q),
    .csr_rd    (csr_rd),
    .cnt_rd    (cnt_rd),
    .ch_over   (ch_over)
);

// File: tb/test_cmt_timer.sv
module test_cmt_timer;

    localparam logic [3:0] A_RUN  = 4'd0;
    localparam logic [3:0] A_CSR0 = 4'd4;
    localparam logic [3:0] A_CNT0 = 4'd5;
    localparam logic [3:0] A_CMP0 = 4'd6;
    localparam logic [3:0] A_CSR1 = 4'd8;
    localparam logic [3:0] A_CNT1 = 4'd9;
    localparam logic [3:0] A_CMP1 = 4'd10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cmt_timer i_cmt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #2;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rdchk(input string req, input string what, input logic [3:0] a, input logic [31:0] exp);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        check(req, what, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic t_reset;
        rdchk("R1", "run reg", A_RUN, 32'h0);
        rdchk("R1", "csr0", A_CSR0, 32'h0);
        rdchk("R1", "cnt0", A_CNT0, 32'h0);
        rdchk("R1 R10", "cmp0 16-bit", A_CMP0, 32'h0000FFFF);
        rdchk("R1", "cmp1 32-bit", A_CMP1, 32'hFFFFFFFF);
        check("R1", "irq", 32'(irq), 32'h0);
    endtask

    task automatic t_shared_run;
        wr(A_CSR0, 32'hFFFF);
        rdchk("R10 R6", "csr0 defined bits only", A_CSR0, 32'h127);
        wr(A_CSR1, 32'hFFFF);
        rdchk("R10 R6", "csr1 defined bits only", A_CSR1, 32'h127);
        wr(A_CSR0, 32'h20);
        wr(A_CSR1, 32'h20);
        wr(A_RUN, 32'h3);
        rdchk("R2", "run reg readback", A_RUN, 32'h3);
        cyc(6);
        rdchk("R2 R3", "cnt0 together", A_CNT0, 32'd6);
        rdchk("R2 R3", "cnt1 together", A_CNT1, 32'd6);
        wr(A_RUN, 32'h0);
        rdchk("R2", "run reg cleared", A_RUN, 32'h0);
        wr(A_CNT0, 32'h0);
        wr(A_CNT1, 32'h0);
    endtask

    task automatic t_prescale8;
        wr(A_CNT1, 32'h0);
        wr(A_CMP1, 32'd1000);
        wr(A_CSR1, 32'h24);
        wr(A_RUN, 32'h2);
        cyc(39);
        rdchk("R3", "div8 before 5th tick", A_CNT1, 32'd4);
        cyc(1);
        rdchk("R3", "div8 5th tick", A_CNT1, 32'd5);
        wr(A_RUN, 32'h0);
        cyc(20);
        rdchk("R8", "stopped counter frozen", A_CNT1, 32'd5);
        wr(A_CNT1, 32'h12345678);
        rdchk("R8", "load while stopped", A_CNT1, 32'h12345678);
        wr(A_CSR1, 32'h0);
    endtask

    task automatic t_periodic16;
        wr(A_CNT0, 32'h0);
        wr(A_CMP0, 32'd3);
        wr(A_CSR0, 32'h20);
        wr(A_RUN, 32'h1);
        cyc(3);
        rdchk("R4", "cnt at compare", A_CNT0, 32'd3);
        rdchk("R4", "no flag yet", A_CSR0, 32'h20);
        cyc(1);
        rdchk("R4", "restart to zero", A_CNT0, 32'd0);
        rdchk("R4", "flag bit7", A_CSR0, 32'hA0);
        check("R7", "irq0 disabled", 32'(irq[0]), 32'h0);
        cyc(1);
        wr(A_CSR0, 32'h20);
        rdchk("R6", "flag cleared by zero", A_CSR0, 32'h20);
        cyc(1);
        wr(A_CSR0, 32'h20);
        rdchk("R6", "set beats clear", A_CSR0, 32'hA0);
        wr(A_CSR0, 32'h1A0);
        check("R7", "irq0 high", 32'(irq[0]), 32'h1);
        wr(A_CSR0, 32'h120);
        check("R7", "irq0 low after clear", 32'(irq[0]), 32'h0);
        cyc(2);
        check("R7", "irq0 on next match", 32'(irq[0]), 32'h1);
        rdchk("R4", "cnt back to zero", A_CNT0, 32'd0);
        wr(A_RUN, 32'h0);
        wr(A_CSR0, 32'h0);
    endtask

    task automatic t_free_run;
        wr(A_CNT0, 32'h0);
        wr(A_CMP0, 32'd3);
        wr(A_CSR0, 32'h0);
        wr(A_RUN, 32'h1);
        cyc(4);
        rdchk("R4", "free-run passes compare", A_CNT0, 32'd4);
        rdchk("R4", "free-run flag", A_CSR0, 32'h80);
        wr(A_RUN, 32'h0);
        wr(A_CSR0, 32'h0);
    endtask

    task automatic t_overshoot;
        wr(A_CNT0, 32'h1FFF0);
        rdchk("R10", "16-bit load truncated", A_CNT0, 32'hFFF0);
        wr(A_CMP0, 32'd5);
        wr(A_CSR0, 32'h20);
        wr(A_RUN, 32'h1);
        cyc(15);
        rdchk("R5", "runs to all ones", A_CNT0, 32'hFFFF);
        rdchk("R5", "no flag above compare", A_CSR0, 32'h20);
        cyc(1);
        rdchk("R5", "wrap to zero", A_CNT0, 32'h0);
        rdchk("R5", "wrap flag only", A_CSR0, 32'h60);
        cyc(6);
        rdchk("R4", "match after wrap", A_CSR0, 32'hE0);
        wr(A_RUN, 32'h0);
        wr(A_CSR0, 32'h0);
        rdchk("R6", "both flags cleared", A_CSR0, 32'h0);
    endtask

    task automatic t_live_compare;
        wr(A_CNT0, 32'h0);
        wr(A_CMP0, 32'd100);
        wr(A_CSR0, 32'h20);
        wr(A_RUN, 32'h1);
        cyc(10);
        rdchk("R3", "div1 count", A_CNT0, 32'd10);
        wr(A_CMP0, 32'd4);
        rdchk("R9", "compare updated live", A_CMP0, 32'd4);
        cyc(5);
        rdchk("R9", "counts past lowered compare", A_CNT0, 32'd16);
        rdchk("R9", "no match when lowered", A_CSR0, 32'h20);
        wr(A_CMP0, 32'd30);
        cyc(13);
        rdchk("R9", "reaches raised compare", A_CNT0, 32'd30);
        cyc(1);
        rdchk("R9", "raised compare matched", A_CSR0, 32'hA0);
        rdchk("R9", "restart at raised compare", A_CNT0, 32'd0);
        wr(A_RUN, 32'h0);
        wr(A_CSR0, 32'h0);
    endtask

    task automatic t_wide32;
        wr(A_CNT0, 32'd7);
        wr(A_CNT1, 32'h0);
        wr(A_CMP1, 32'd3);
        wr(A_CSR1, 32'h20);
        wr(A_RUN, 32'h2);
        cyc(4);
        rdchk("R4", "32-bit restart", A_CNT1, 32'h0);
        rdchk("R4", "32-bit flag bit15", A_CSR1, 32'h8020);
        check("R7", "irq1 disabled", 32'(irq[1]), 32'h0);
        wr(A_CNT1, 32'h55);
        rdchk("R8", "write ignored while running", A_CNT1, 32'd1);
        rdchk("R2", "other channel idle", A_CNT0, 32'd7);
        wr(A_RUN, 32'h0);
        wr(A_CSR1, 32'h0);
        wr(A_CNT1, 32'hFFFFFFF0);
        wr(A_CMP1, 32'd2);
        wr(A_CSR1, 32'h20);
        wr(A_RUN, 32'h2);
        cyc(16);
        rdchk("R5", "32-bit wrap to zero", A_CNT1, 32'h0);
        rdchk("R5", "32-bit wrap flag bit14", A_CSR1, 32'h4020);
        wr(A_RUN, 32'h0);
        wr(A_CSR1, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_shared_run();
        t_prescale8();
        t_periodic16();
        t_free_run();
        t_overshoot();
        t_live_compare();
        t_wide32();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule